// File: doc/BRIEF.md
# ASID-Tagged I/O Translation Buffer with Selective Invalidation

This block is a small, fully associative translation cache for a 32-bit I/O virtual address space with 4 KiB pages. Each slot holds a 7-bit address-space tag, a 20-bit virtual page number, a 20-bit physical frame number and three permission flags: read, write and non-secure. Lookups are combinational. A caller presents a tag and a virtual address and gets back hit or miss, the translated physical address and the permissions in the same cycle.

A page-table walker, outside this block, installs translations through a one-cycle fill strobe. Software drops stale translations by writing a 32-bit invalidation command. One command word can remove every slot, every slot of one address space, every slot whose address lies in one 4 MiB section, or every slot whose address lies in one 16 KiB group. The section and group matches can be limited to a single address space or applied to all of them.

Top module: `iotlb_asid`

## Requirements
- R1: After reset every slot is invalid, so every lookup misses.
- R2: A lookup hits only when some valid slot's tag equals `lk_asid` and its page number equals `lk_va[31:12]`. On a hit, `lk_pa` is the slot's frame number above `lk_va[11:0]`, and `lk_rd`/`lk_wr`/`lk_ns` are the slot's flags. On a miss, `lk_pa` and all three flags are 0. The result is combinational on the current contents.
- R3: A fill presented with `fill_en` high at a clock edge is visible to lookups from the next cycle on.
- R4: A fill of a new tag and page pair goes to the lowest-numbered invalid slot. When no slot is invalid, it goes to the slot named by a rotating pointer. The pointer is 0 after reset and steps by one, modulo the slot count, only on fills that evict a slot this way.
- R5: An invalidation command written with `inv_wr` high at a clock edge takes effect after that edge. A lookup in the cycle of the write still sees the old contents.
- R6: When command bit 31 is 1, only slots whose tag equals command bits [30:24] are candidates. When bit 31 is 0, slots are candidates whatever their tag.
- R7: When command bits [1:0] are 0, every candidate slot is invalidated.
- R8: When command bits [1:0] are 2, a candidate slot is invalidated if its `VA[31:22]` equals command bits [19:10].
- R9: When command bits [1:0] are 3, a candidate slot is invalidated if its `VA[31:14]` equals command bits [19:2].
- R10: When command bits [1:0] are 1 (a reserved code), no slot is invalidated, whatever the other command bits are.
- R11: A fill whose tag and page pair is already held by a valid slot overwrites that slot's frame and flags. It creates no second copy, and it does not step the rotating pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_asid | input | 7 | Address-space tag of the lookup |
| lk_va | input | 32 | Virtual address of the lookup |
| lk_hit | output | 1 | Lookup found a valid matching slot |
| lk_pa | output | 32 | Translated physical address, 0 on a miss |
| lk_rd | output | 1 | Read permission of the hit slot |
| lk_wr | output | 1 | Write permission of the hit slot |
| lk_ns | output | 1 | Non-secure flag of the hit slot |
| fill_en | input | 1 | Install a translation at this clock edge |
| fill_asid | input | 7 | Tag of the translation being installed |
| fill_vpn | input | 20 | Virtual page number being installed |
| fill_pfn | input | 20 | Physical frame number being installed |
| fill_rd | input | 1 | Read permission being installed |
| fill_wr | input | 1 | Write permission being installed |
| fill_ns | input | 1 | Non-secure flag being installed |
| inv_wr | input | 1 | Apply `inv_cmd` at this clock edge |
| inv_cmd | input | 32 | Invalidation command word |

## Verification
The bench sweeps every address-match code, both with and without tag matching, over a slot population built to sit on both sides of each boundary: the same 16 KiB group, the same 4 MiB section but a different group, and the same page under another tag. A design that compared the wrong bit range would drop the neighbouring group or keep part of the section. A design that ignored bit 31 would spare or kill the other tag's copy. A design that treated code 1 as "all" would empty the buffer. Refilling a present page and then invalidating its address space exposes a duplicate-creating fill, because the stale copy goes on hitting. Three fills into a full buffer expose a rotating pointer that starts in the wrong place or steps on the wrong fills. A lookup made in the same cycle as an invalidate-all must still hit; a design that applied commands combinationally would miss it.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;
    localparam int ASID_W     = 7;
    localparam int VA_W       = 32;
    localparam int PG_SHIFT   = 12;
    localparam int VPN_W      = VA_W - PG_SHIFT;
    localparam int PFN_W      = 20;
    localparam int PA_W       = PFN_W + PG_SHIFT;
    localparam int SECT_SHIFT = 22;
    localparam int GRP_SHIFT  = 14;
    localparam int SECT_W     = VA_W - SECT_SHIFT;
    localparam int GRP_W      = VA_W - GRP_SHIFT;
    localparam int CMD_W      = 32;
    localparam int CMD_EN_BIT = 31;
    localparam int CMD_ASID_LSB = 24;

    typedef enum logic [1:0] {
        AM_ALL  = 2'd0,
        AM_RSVD = 2'd1,
        AM_SECT = 2'd2,
        AM_GRP  = 2'd3
    } addr_mode_e;

    typedef struct packed {
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
        logic              rd;
        logic              wr;
        logic              ns;
    } tlb_ent_t;
endpackage

// File: rtl/iotlb_inval_sel.sv
module iotlb_inval_sel
    import iotlb_pkg::*;
#(
    parameter int N_ENT = 8
) (
    input  logic [CMD_W-1:0]           cmd,
    input  logic [N_ENT-1:0]           valid,
    input  tlb_ent_t [N_ENT-1:0]       ents,
    output logic [N_ENT-1:0]           kill
);
    logic              asid_en;
    logic [ASID_W-1:0] cmd_asid;
    addr_mode_e        mode;
    logic              unused_cmd_bits;

    assign asid_en         = cmd[CMD_EN_BIT];
    assign cmd_asid        = cmd[CMD_ASID_LSB +: ASID_W];
    assign mode            = addr_mode_e'(cmd[1:0]);
    assign unused_cmd_bits = ^cmd[CMD_ASID_LSB-1:VPN_W];

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        logic asid_ok;
        logic addr_ok;
        always_comb begin
            asid_ok = !asid_en || (ents[i].asid == cmd_asid);
            unique case (mode)
                AM_ALL:  addr_ok = 1'b1;
                AM_SECT: addr_ok = ents[i].vpn[VPN_W-1 -: SECT_W] == cmd[VPN_W-1 -: SECT_W];
                AM_GRP:  addr_ok = ents[i].vpn[VPN_W-1 -: GRP_W] == cmd[VPN_W-1 -: GRP_W];
                default: addr_ok = 1'b0;
            endcase
            kill[i] = valid[i] && asid_ok && addr_ok;
        end
    end
endmodule

// File: rtl/iotlb_cam.sv
module iotlb_cam
    import iotlb_pkg::*;
#(
    parameter int N_ENT = 8,
    parameter int IDX_W = 3
) (
    input  tlb_ent_t [N_ENT-1:0] ents,
    input  logic [N_ENT-1:0]     valid,
    input  logic [ASID_W-1:0]    asid,
    input  logic [VPN_W-1:0]     vpn,
    output logic                 hit,
    output logic [IDX_W-1:0]     idx
);
    logic [N_ENT-1:0] match;

    for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
        assign match[i] = valid[i] && (ents[i].asid == asid) && (ents[i].vpn == vpn);
    end

    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/iotlb_victim.sv
module iotlb_victim #(
    parameter int N_ENT = 8,
    parameter int IDX_W = 3
) (
    input  logic [N_ENT-1:0] valid,
    input  logic [IDX_W-1:0] ptr,
    output logic [IDX_W-1:0] slot,
    output logic             from_ptr
);
    always_comb begin
        slot     = ptr;
        from_ptr = 1'b1;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                slot     = IDX_W'(i);
                from_ptr = 1'b0;
            end
        end
    end
endmodule

// File: rtl/iotlb_asid.sv
module iotlb_asid
    import iotlb_pkg::*;
#(
    parameter int N_ENT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VA_W-1:0]   lk_va,
    output logic              lk_hit,
    output logic [PA_W-1:0]   lk_pa,
    output logic              lk_rd,
    output logic              lk_wr,
    output logic              lk_ns,
    input  logic              fill_en,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic              fill_rd,
    input  logic              fill_wr,
    input  logic              fill_ns,
    input  logic              inv_wr,
    input  logic [CMD_W-1:0]  inv_cmd
);
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENT - 1);

    typedef struct packed {
        logic [N_ENT-1:0]     valid;
        tlb_ent_t [N_ENT-1:0] ent;
        logic [IDX_W-1:0]     ptr;
    } state_t;

    state_t st_q, st_d;

    logic             lk_found;
    logic [IDX_W-1:0] lk_idx;
    logic             dup_hit;
    logic [IDX_W-1:0] dup_idx;
    logic [IDX_W-1:0] vic_slot;
    logic             vic_from_ptr;
    logic [N_ENT-1:0] kill;
    logic [IDX_W-1:0] fill_slot;
    tlb_ent_t         fill_ent;
    tlb_ent_t         hit_ent;

    iotlb_cam #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_lk_cam (
        .ents (st_q.ent),
        .valid(st_q.valid),
        .asid (lk_asid),
        .vpn  (lk_va[VA_W-1:PG_SHIFT]),
        .hit  (lk_found),
        .idx  (lk_idx)
    );

    iotlb_cam #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_dup_cam (
        .ents (st_q.ent),
        .valid(st_q.valid),
        .asid (fill_asid),
        .vpn  (fill_vpn),
        .hit  (dup_hit),
        .idx  (dup_idx)
    );

    iotlb_victim #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_victim (
        .valid   (st_q.valid),
        .ptr     (st_q.ptr),
        .slot    (vic_slot),
        .from_ptr(vic_from_ptr)
    );

    iotlb_inval_sel #(.N_ENT(N_ENT)) u_inval (
        .cmd  (inv_cmd),
        .valid(st_q.valid),
        .ents (st_q.ent),
        .kill (kill)
    );

    assign fill_slot = dup_hit ? dup_idx : vic_slot;
    assign fill_ent  = '{asid: fill_asid, vpn: fill_vpn, pfn: fill_pfn,
                         rd: fill_rd, wr: fill_wr, ns: fill_ns};

    always_comb begin
        st_d = st_q;
        if (inv_wr) begin
            st_d.valid = st_q.valid & ~kill;
        end
        if (fill_en) begin
            st_d.ent[fill_slot]   = fill_ent;
            st_d.valid[fill_slot] = 1'b1;
            if (!dup_hit && vic_from_ptr) begin
                st_d.ptr = (st_q.ptr == LAST_IDX) ? '0 : st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        hit_ent = st_q.ent[lk_idx];
        lk_hit  = lk_found;
        lk_pa   = lk_found ? {hit_ent.pfn, lk_va[PG_SHIFT-1:0]} : '0;
        lk_rd   = lk_found && hit_ent.rd;
        lk_wr   = lk_found && hit_ent.wr;
        lk_ns   = lk_found && hit_ent.ns;
    end
endmodule

// File: rtl/iotlb_asid_chk.sv
module iotlb_asid_chk
    import iotlb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ASID_W-1:0] lk_asid,
    input logic [VA_W-1:0]   lk_va,
    input logic              lk_hit,
    input logic [PA_W-1:0]   lk_pa,
    input logic              lk_rd,
    input logic              lk_wr,
    input logic              lk_ns,
    input logic              fill_en,
    input logic [ASID_W-1:0] fill_asid,
    input logic [VPN_W-1:0]  fill_vpn,
    input logic [PFN_W-1:0]  fill_pfn,
    input logic              inv_wr,
    input logic [CMD_W-1:0]  inv_cmd
);
    // R1
    reset_empty_chk: assert property (@(posedge clk) !rst_n |=> !lk_hit);

    // R2
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_pa == '0 && !lk_rd && !lk_wr && !lk_ns));

    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_pa[PG_SHIFT-1:0] == lk_va[PG_SHIFT-1:0]);

    // R3
    fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !inv_wr) |=>
            (!(lk_asid == $past(fill_asid) && lk_va[VA_W-1:PG_SHIFT] == $past(fill_vpn))
             || (lk_hit && lk_pa[PA_W-1:PG_SHIFT] == $past(fill_pfn))));

    // R7
    inv_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_wr && !inv_cmd[CMD_EN_BIT] && inv_cmd[1:0] == 2'd0 && !fill_en) |=> !lk_hit);

    // R10
    rsvd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_wr && inv_cmd[1:0] == 2'd1 && !fill_en) |=>
            (lk_hit == $past(lk_hit) || lk_asid != $past(lk_asid) || lk_va != $past(lk_va)));
endmodule

bind iotlb_asid iotlb_asid_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_asid  (lk_asid),
    .lk_va    (lk_va),
    .lk_hit   (lk_hit),
    .lk_pa    (lk_pa),
    .lk_rd    (lk_rd),
    .lk_wr    (lk_wr),
    .lk_ns    (lk_ns),
    .fill_en  (fill_en),
    .fill_asid(fill_asid),
    .fill_vpn (fill_vpn),
    .fill_pfn (fill_pfn),
    .inv_wr   (inv_wr),
    .inv_cmd  (inv_cmd)
);

// File: tb/sim_iotlb_asid.sv
module sim_iotlb_asid;
    localparam int NE = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  lk_asid = '0;
    logic [31:0] lk_va = '0;
    logic        lk_hit;
    logic [31:0] lk_pa;
    logic        lk_rd, lk_wr, lk_ns;
    logic        fill_en = 1'b0;
    logic [6:0]  fill_asid = '0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_pfn = '0;
    logic        fill_rd = 1'b0, fill_wr = 1'b0, fill_ns = 1'b0;
    logic        inv_wr = 1'b0;
    logic [31:0] inv_cmd = '0;

    int n_vec = 0;
    int n_fail = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    iotlb_asid #(.N_ENT(NE)) u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_asid(lk_asid), .lk_va(lk_va), .lk_hit(lk_hit), .lk_pa(lk_pa),
        .lk_rd(lk_rd), .lk_wr(lk_wr), .lk_ns(lk_ns),
        .fill_en(fill_en), .fill_asid(fill_asid), .fill_vpn(fill_vpn),
        .fill_pfn(fill_pfn), .fill_rd(fill_rd), .fill_wr(fill_wr), .fill_ns(fill_ns),
        .inv_wr(inv_wr), .inv_cmd(inv_cmd)
    );

    // reference model built from the requirements
    logic        m_v [NE];
    logic [6:0]  m_a [NE];
    logic [19:0] m_vp[NE];
    logic [19:0] m_pf[NE];
    logic [2:0]  m_pm[NE];
    int          m_ptr = 0;

    logic [6:0]  pr_a[64];
    logic [19:0] pr_v[64];
    int          n_pr = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: run hung, got cycle %0d expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    function automatic logic [6:0] base_asid(input int i);
        case (i)
            0, 1, 2, 3: return 7'd5;
            4, 5:       return 7'd9;
            6:          return 7'h7f;
            default:    return 7'd0;
        endcase
    endfunction

    function automatic logic [19:0] base_vpn(input int i);
        case (i)
            0:       return 20'h00400;
            1:       return 20'h00401;
            2:       return 20'h00404;
            3:       return 20'h00800;
            4:       return 20'h00400;
            5:       return 20'h00805;
            6:       return 20'hFFFFF;
            default: return 20'h00000;
        endcase
    endfunction

    task automatic add_probe(input logic [6:0] a, input logic [19:0] v);
        if (n_pr < 64) begin
            pr_a[n_pr] = a;
            pr_v[n_pr] = v;
            n_pr++;
        end
    endtask

    task automatic model_fill(input logic [6:0] a, input logic [19:0] v,
                              input logic [19:0] p, input logic [2:0] pm);
        int slot = -1;
        for (int i = 0; i < NE; i++)
            if (slot < 0 && m_v[i] && m_a[i] == a && m_vp[i] == v) slot = i;
        if (slot < 0)
            for (int i = 0; i < NE; i++)
                if (slot < 0 && !m_v[i]) slot = i;
        if (slot < 0) begin
            slot  = m_ptr;
            m_ptr = (m_ptr + 1) % NE;
        end
        m_v[slot] = 1'b1; m_a[slot] = a; m_vp[slot] = v; m_pf[slot] = p; m_pm[slot] = pm;
    endtask

    task automatic model_inv(input logic [31:0] c);
        for (int i = 0; i < NE; i++) begin
            bit a_ok = !c[31] || (m_a[i] == c[30:24]);
            bit v_ok;
            case (c[1:0])
                2'd0:    v_ok = 1;
                2'd2:    v_ok = (m_vp[i][19:10] == c[19:10]);
                2'd3:    v_ok = (m_vp[i][19:2] == c[19:2]);
                default: v_ok = 0;
            endcase
            if (m_v[i] && a_ok && v_ok) m_v[i] = 1'b0;
        end
    endtask

    task automatic do_fill(input logic [6:0] a, input logic [19:0] v,
                           input logic [19:0] p, input logic [2:0] pm);
        @(negedge clk);
        fill_en = 1'b1; fill_asid = a; fill_vpn = v; fill_pfn = p;
        {fill_rd, fill_wr, fill_ns} = pm;
        @(negedge clk);
        fill_en = 1'b0;
        model_fill(a, v, p, pm);
    endtask

    task automatic do_inv(input logic [31:0] c);
        @(negedge clk);
        inv_wr = 1'b1; inv_cmd = c;
        @(negedge clk);
        inv_wr = 1'b0;
        model_inv(c);
    endtask

    task automatic fill_base();
        for (int i = 0; i < NE; i++)
            do_fill(base_asid(i), base_vpn(i), 20'h10000 + 20'(i * 'h111), 3'(i));
    endtask

    task automatic check_one(input logic [6:0] a, input logic [31:0] va,
                             input string tag, input bit wait_edge);
        logic        eh;
        logic [31:0] ep;
        logic [2:0]  epm;
        if (wait_edge) @(negedge clk);
        lk_asid = a; lk_va = va;
        #1;
        eh = 1'b0; ep = '0; epm = '0;
        for (int i = 0; i < NE; i++)
            if (m_v[i] && m_a[i] == a && m_vp[i] == va[31:12]) begin
                eh = 1'b1; ep = {m_pf[i], va[11:0]}; epm = m_pm[i];
            end
        n_vec++;
        if (lk_hit !== eh || lk_pa !== ep || {lk_rd, lk_wr, lk_ns} !== epm) begin
            n_fail++;
            $display("FAIL %s asid=%h va=%h: got hit=%b pa=%h perm=%b, expected hit=%b pa=%h perm=%b",
                     tag, a, va, lk_hit, lk_pa, {lk_rd, lk_wr, lk_ns}, eh, ep, epm);
        end
    endtask

    task automatic check_probes(input string tag);
        for (int k = 0; k < n_pr; k++)
            check_one(pr_a[k], {pr_v[k], 12'(12'hA5C ^ 12'(k * 37))}, tag, 1'b1);
    endtask

    initial begin
        for (int i = 0; i < NE; i++) begin
            m_v[i] = 0; m_a[i] = '0; m_vp[i] = '0; m_pf[i] = '0; m_pm[i] = '0;
        end
        for (int i = 0; i < NE; i++) add_probe(base_asid(i), base_vpn(i));
        add_probe(7'd5, 20'h00402);
        add_probe(7'd3, 20'h00400);
        add_probe(7'd9, 20'h00401);

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        check_probes("R1");

        // R2 / R3 / R4: fills land in empty slots and become visible
        fill_base();
        check_probes("R2");
        check_probes("R3");

        // R5: lookup in the same cycle as an invalidate-all sees old contents
        @(negedge clk);
        inv_wr = 1'b1; inv_cmd = 32'h0000_0000;
        check_one(7'd5, 32'h0040_0ABC, "R5", 1'b0);
        @(negedge clk);
        inv_wr = 1'b0;
        model_inv(32'h0000_0000);
        check_probes("R5");

        // R11: refill of a present page overwrites, no second copy
        fill_base();
        do_fill(7'h7f, 20'hFFFFF, 20'hABCDE, 3'b101);
        check_probes("R11");
        do_inv({1'b1, 7'h7f, 24'h000000});
        check_probes("R11");

        // R6: tag match disabled, section mode, garbage in the tag field
        do_inv(32'h3300_0802);
        check_probes("R6");

        // R4: rotating victim once the buffer is full
        do_inv(32'h0000_0000);
        fill_base();
        for (int k = 0; k < 3; k++) begin
            add_probe(7'd2, 20'h12340 + 20'(k));
            do_fill(7'd2, 20'h12340 + 20'(k), 20'h0BEEF + 20'(k), 3'b110);
            check_probes("R4");
        end

        // sweep over every address mode with and without tag matching
        for (int am = 0; am < 2; am++) begin
            for (int md = 0; md < 4; md++) begin
                string tg;
                logic [31:0] c;
                case (md)
                    0:       tg = (am == 0) ? "R7" : "R6";
                    1:       tg = "R10";
                    2:       tg = "R8";
                    default: tg = "R9";
                endcase
                do_inv(32'h0000_0000);
                fill_base();
                c = {am[0], 7'd5, 4'h0, 18'(20'h00404 >> 2), md[1:0]};
                do_inv(c);
                check_probes(tg);
            end
        end

        // R10: reserved code with every other bit set
        fill_base();
        do_inv(32'hFFFF_FFFD);
        check_probes("R10");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule